// File: doc/BRIEF.md
# Reset Sequencer with Serial EEPROM Configuration Preload

This block owns device reset and power-up configuration. An asynchronous active-low hardware reset, or a software global-reset bit in the control register, clears every configuration register. The block then reads seven 16-bit words from an external three-wire serial EEPROM and stores them in five places: the configuration parameter register, the low half of the 32-bit control register, the subsystem vendor ID, the subsystem ID and the 48-bit station address. Other bits of the control register start pulses that reset individual functional units while the rest of the device keeps running.

A forced-configuration strap lets a board without an EEPROM skip the read. The strap is sampled at the start of every preload. When it is set, the block presents fixed bus defaults at once and raises the done flag.

Inside the block, a sequencer asks a serial reader for one word at a time over a valid/ready pair. The sequencer holds a request until the reader accepts it, and the reader accepts only while idle. The reader returns each word with a one-cycle valid pulse and cannot be stalled. Host writes, the strap and the outputs are plain level signals.

Top module: `cfg_boot_ctrl`

## Requirements
- R1: With the strap low, after reset the block reads EEPROM words 0 to 6 and stores them as follows: word 0 in `cfg_parm`, word 1 in `ctrl_reg[15:0]`, word 2 in `subsys_vid`, word 3 in `subsys_id`, and words 4, 5 and 6 in `station_addr[15:0]`, `[31:16]` and `[47:32]`.
- R2: The preload never writes `ctrl_reg[31:16]`. These bits read 0 when `load_done` rises.
- R3: Each word is a separate frame. `ee_cs` goes high, then nine command bits are sent on `ee_di`, most significant bit first: the header 1,1,0 followed by a 6-bit address. Sixteen data bits follow, most significant bit first. Each bit occupies one `ee_sk` period of SK_DIV clocks (8), with `ee_sk` high for the second half. `ee_di` changes only while `ee_sk` is low. `ee_do` is sampled just before `ee_sk` falls. `ee_cs` returns low between words.
- R4: `load_done` is low from reset until the last word is stored, then goes high.
- R5: Host writes presented while `load_done` is low have no effect. This includes a write in the cycle in which the last word is stored.
- R6: While `load_done` is high, a host write with `host_wr_sel`=1 loads `cfg_parm` from `host_wr_data[15:0]`. A write with `host_wr_sel`=0 and bit 31 clear loads `ctrl_reg[15:0]` and `ctrl_reg[30:20]` from the same bit positions of `host_wr_data`.
- R7: A control write with bit 16+i set and bit 31 clear drives `unit_rst[i]` high for exactly UNIT_LEN (16) cycles, starting in the cycle after the write. `ctrl_reg[16+i]` reads 1 during the pulse. Other units are unaffected.
- R8: A control write with bit 31 set clears all configuration registers in the next cycle. `ctrl_reg[31]` and every `unit_rst` line are then high for SRST_LEN (4) cycles, after which bit 31 clears and the preload runs again.
- R9: With the strap high at preload start, `ee_cs` stays low and `load_done` rises at once. The bus defaults are `io_base`=16'h0200, `io_cyc_en`=1, `mem_cyc_en`=0, `bus_mst_en`=1 and `rom_cyc_en`=0. With the strap low, these five outputs are all 0.
- R10: Asserting `hw_rst_n` low clears all configuration registers at once. Releasing it restarts the preload.
- R11: When a control write sets bit 31 together with unit bits, the global reset takes precedence and no unit pulse starts. Each `unit_rst` line is then high for only the SRST_LEN cycles of the global reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| hw_rst_n | input | 1 | Asynchronous active-low hardware reset |
| strap_forced | input | 1 | Forced-configuration strap, sampled at preload start |
| host_wr_en | input | 1 | Host register write strobe |
| host_wr_sel | input | 1 | Write target: 0 selects the control register, 1 selects the configuration parameter |
| host_wr_data | input | 32 | Host write data |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Serial data to the EEPROM |
| ee_do | input | 1 | Serial data from the EEPROM |
| cfg_parm | output | 16 | Configuration parameter register |
| ctrl_reg | output | 32 | Control register: [31] global reset active, [30:20] host bits, [19:16] unit reset active, [15:0] preloaded half |
| subsys_vid | output | 16 | Subsystem vendor ID |
| subsys_id | output | 16 | Subsystem ID |
| station_addr | output | 48 | Station address |
| io_base | output | 16 | I/O base address default |
| io_cyc_en | output | 1 | I/O target cycles enable |
| mem_cyc_en | output | 1 | Memory target cycles enable |
| bus_mst_en | output | 1 | Bus master enable |
| rom_cyc_en | output | 1 | Expansion ROM cycles enable |
| unit_rst | output | 4 | Per-unit reset lines |
| load_done | output | 1 | Preload complete |

## Verification
Two pairs of functions can fall in the same cycle. In the first, a host write arrives in the cycle in which the final EEPROM word is stored. The bench provokes this by counting falling edges of chip select and driving a write to the configuration parameter in the cycle that follows the seventh. It then checks that the stored value is still the EEPROM word and that `load_done` has risen. In the second, one control write requests both a global reset and a unit reset. The bench counts the high cycles of that unit's reset line and expects SRST_LEN rather than UNIT_LEN, then confirms that the preload values return.

// File: rtl/cfg_boot_pkg.sv
package cfg_boot_pkg;
  typedef enum logic [2:0] {SQ_START, SQ_REQ, SQ_WAIT, SQ_DONE, SQ_SRST} seq_st_t;
  typedef enum logic [1:0] {RD_IDLE, RD_SHIFT, RD_GAP} rd_st_t;

  localparam int          WORD_W         = 16;
  localparam int          NWORDS         = 7;
  localparam logic [2:0]  EE_RD_HDR      = 3'b110;
  localparam logic [15:0] FORCED_IO_BASE = 16'h0200;
endpackage

// File: rtl/ee_word_rd.sv
module ee_word_rd
  import cfg_boot_pkg::*;
#(
  parameter int AW  = 6,
  parameter int DIV = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [AW-1:0]     req_addr,
  output logic              dat_valid,
  output logic [WORD_W-1:0] dat_word,
  output logic              ee_cs,
  output logic              ee_sk,
  output logic              ee_di,
  input  logic              ee_do
);
  localparam int CMD_W  = 3 + AW;
  localparam int SLOTS  = CMD_W + WORD_W;
  localparam int SLOT_W = $clog2(SLOTS + 1);
  localparam int PH_W   = $clog2(DIV);
  localparam int HALF   = DIV / 2;

  rd_st_t              st;
  logic [PH_W-1:0]     phase;
  logic [SLOT_W-1:0]   slot;
  logic [CMD_W-1:0]    cmd;
  logic [WORD_W-1:0]   shreg;

  assign req_ready = (st == RD_IDLE);
  assign dat_word  = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= RD_IDLE;
      phase     <= '0;
      slot      <= '0;
      cmd       <= '0;
      shreg     <= '0;
      ee_cs     <= 1'b0;
      ee_sk     <= 1'b0;
      ee_di     <= 1'b0;
      dat_valid <= 1'b0;
    end else if (clr) begin
      st        <= RD_IDLE;
      phase     <= '0;
      ee_cs     <= 1'b0;
      ee_sk     <= 1'b0;
      ee_di     <= 1'b0;
      dat_valid <= 1'b0;
    end else begin
      dat_valid <= 1'b0;
      case (st)
        RD_IDLE: begin
          if (req_valid) begin
            cmd   <= {EE_RD_HDR[1:0], req_addr, 1'b0};
            ee_di <= EE_RD_HDR[2];
            ee_cs <= 1'b1;
            ee_sk <= 1'b0;
            phase <= '0;
            slot  <= '0;
            st    <= RD_SHIFT;
          end
        end
        RD_SHIFT: begin
          if (phase == PH_W'(HALF - 1)) ee_sk <= 1'b1;
          if (phase == PH_W'(DIV - 1)) begin
            phase <= '0;
            ee_sk <= 1'b0;
            ee_di <= cmd[CMD_W-1];
            cmd   <= cmd << 1;
            if (slot >= SLOT_W'(CMD_W)) shreg <= {shreg[WORD_W-2:0], ee_do};
            if (slot == SLOT_W'(SLOTS - 1)) begin
              ee_cs     <= 1'b0;
              ee_di     <= 1'b0;
              dat_valid <= 1'b1;
              st        <= RD_GAP;
            end else begin
              slot <= slot + 1'b1;
            end
          end else begin
            phase <= phase + 1'b1;
          end
        end
        RD_GAP: begin
          if (phase == PH_W'(DIV - 1)) begin
            phase <= '0;
            st    <= RD_IDLE;
          end else begin
            phase <= phase + 1'b1;
          end
        end
        default: st <= RD_IDLE;
      endcase
    end
  end

  assert_sk_in_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ee_sk |-> ee_cs);
  assert_accept_opens_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !clr) |=> ee_cs);
  assert_word_after_close_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dat_valid |-> !ee_cs);
endmodule

// File: rtl/unit_rst_gen.sv
module unit_rst_gen #(
  parameter int LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic pulse
);
  localparam int CW = $clog2(LEN + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] run_q;

  assign pulse = (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (trig)   cnt <= CW'(LEN);
    else if (pulse)  cnt <= cnt - 1'b1;
  end

  // run length of the current pulse, used by the checks below
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  run_q <= '0;
    else if (!pulse)             run_q <= '0;
    else if (run_q != CW'(LEN))  run_q <= run_q + 1'b1;
  end

  assert_trig_starts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> pulse);
  assert_pulse_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pulse) |-> (run_q == CW'(LEN)));
endmodule

// File: rtl/cfg_boot_ctrl.sv
module cfg_boot_ctrl
  import cfg_boot_pkg::*;
#(
  parameter int NUNIT    = 4,
  parameter int UNIT_LEN = 16,
  parameter int SRST_LEN = 4,
  parameter int EE_AW    = 6,
  parameter int SK_DIV   = 8
) (
  input  logic             clk,
  input  logic             hw_rst_n,
  input  logic             strap_forced,
  input  logic             host_wr_en,
  input  logic             host_wr_sel,
  input  logic [31:0]      host_wr_data,
  output logic             ee_cs,
  output logic             ee_sk,
  output logic             ee_di,
  input  logic             ee_do,
  output logic [15:0]      cfg_parm,
  output logic [31:0]      ctrl_reg,
  output logic [15:0]      subsys_vid,
  output logic [15:0]      subsys_id,
  output logic [47:0]      station_addr,
  output logic [15:0]      io_base,
  output logic             io_cyc_en,
  output logic             mem_cyc_en,
  output logic             bus_mst_en,
  output logic             rom_cyc_en,
  output logic [NUNIT-1:0] unit_rst,
  output logic             load_done
);
  localparam int IDX_W   = $clog2(NWORDS);
  localparam int UNIT_LO = 16;
  localparam int UNIT_HI = UNIT_LO + NUNIT - 1;
  localparam int MISC_LO = UNIT_HI + 1;
  localparam int SR_W    = $clog2(SRST_LEN + 1);

  seq_st_t           st;
  logic [IDX_W-1:0]  idx;
  logic [SR_W-1:0]   srst_cnt;
  logic              forced_q;
  logic [15:0]       cfg_q, ctrl_lo_q, vid_q, ssid_q;
  logic [47:0]       sta_q;
  logic [30:MISC_LO] ctrl_misc_q;

  logic              rd_req_valid, rd_req_ready, rd_dat_valid, rd_clr;
  logic [WORD_W-1:0] rd_dat_word;
  logic [NUNIT-1:0]  unit_busy, unit_trig;
  logic              host_ok, glob_req, in_srst;

  assign load_done = (st == SQ_DONE);
  assign in_srst   = (st == SQ_SRST);
  assign host_ok   = host_wr_en && load_done;
  assign glob_req  = host_ok && !host_wr_sel && host_wr_data[31];

  assign rd_req_valid = (st == SQ_REQ);
  assign rd_clr       = in_srst;

  ee_word_rd #(.AW(EE_AW), .DIV(SK_DIV)) u_rd (
    .clk       (clk),
    .rst_n     (hw_rst_n),
    .clr       (rd_clr),
    .req_valid (rd_req_valid),
    .req_ready (rd_req_ready),
    .req_addr  (EE_AW'(idx)),
    .dat_valid (rd_dat_valid),
    .dat_word  (rd_dat_word),
    .ee_cs     (ee_cs),
    .ee_sk     (ee_sk),
    .ee_di     (ee_di),
    .ee_do     (ee_do)
  );

  for (genvar i = 0; i < NUNIT; i++) begin : g_unit
    assign unit_trig[i] = host_ok && !host_wr_sel && !host_wr_data[31]
                          && host_wr_data[UNIT_LO+i];
    unit_rst_gen #(.LEN(UNIT_LEN)) u_gen (
      .clk   (clk),
      .rst_n (hw_rst_n),
      .trig  (unit_trig[i]),
      .pulse (unit_busy[i])
    );
  end

  assign unit_rst     = unit_busy | {NUNIT{in_srst}};
  assign ctrl_reg     = {in_srst, ctrl_misc_q, unit_busy, ctrl_lo_q};
  assign cfg_parm     = cfg_q;
  assign subsys_vid   = vid_q;
  assign subsys_id    = ssid_q;
  assign station_addr = sta_q;
  assign io_base      = forced_q ? FORCED_IO_BASE : 16'h0000;
  assign io_cyc_en    = forced_q;
  assign mem_cyc_en   = 1'b0;
  assign bus_mst_en   = forced_q;
  assign rom_cyc_en   = 1'b0;

  always_ff @(posedge clk or negedge hw_rst_n) begin
    if (!hw_rst_n) begin
      st          <= SQ_START;
      idx         <= '0;
      srst_cnt    <= '0;
      forced_q    <= 1'b0;
      cfg_q       <= '0;
      ctrl_lo_q   <= '0;
      ctrl_misc_q <= '0;
      vid_q       <= '0;
      ssid_q      <= '0;
      sta_q       <= '0;
    end else begin
      case (st)
        SQ_START: begin
          forced_q <= strap_forced;
          idx      <= '0;
          st       <= strap_forced ? SQ_DONE : SQ_REQ;
        end
        SQ_REQ: if (rd_req_ready) st <= SQ_WAIT;
        SQ_WAIT: begin
          if (rd_dat_valid) begin
            case (idx)
              IDX_W'(0): cfg_q            <= rd_dat_word;
              IDX_W'(1): ctrl_lo_q        <= rd_dat_word;
              IDX_W'(2): vid_q            <= rd_dat_word;
              IDX_W'(3): ssid_q           <= rd_dat_word;
              IDX_W'(4): sta_q[15:0]      <= rd_dat_word;
              IDX_W'(5): sta_q[31:16]     <= rd_dat_word;
              default:   sta_q[47:32]     <= rd_dat_word;
            endcase
            if (idx == IDX_W'(NWORDS - 1)) begin
              st <= SQ_DONE;
            end else begin
              idx <= idx + 1'b1;
              st  <= SQ_REQ;
            end
          end
        end
        SQ_DONE: begin
          if (glob_req) begin
            forced_q    <= 1'b0;
            cfg_q       <= '0;
            ctrl_lo_q   <= '0;
            ctrl_misc_q <= '0;
            vid_q       <= '0;
            ssid_q      <= '0;
            sta_q       <= '0;
            srst_cnt    <= SR_W'(SRST_LEN - 1);
            st          <= SQ_SRST;
          end else if (host_ok) begin
            if (host_wr_sel) begin
              cfg_q <= host_wr_data[15:0];
            end else begin
              ctrl_lo_q   <= host_wr_data[15:0];
              ctrl_misc_q <= host_wr_data[30:MISC_LO];
            end
          end
        end
        SQ_SRST: begin
          if (srst_cnt == '0) st <= SQ_START;
          else                srst_cnt <= srst_cnt - 1'b1;
        end
        default: st <= SQ_START;
      endcase
    end
  end

  assert_upper_clear_at_done_R2: assert property (@(posedge clk) disable iff (!hw_rst_n)
    $rose(load_done) |-> (ctrl_reg[31:MISC_LO] == '0));
  assert_done_after_last_word_R4: assert property (@(posedge clk) disable iff (!hw_rst_n)
    $rose(load_done) |-> ($past(rd_dat_valid) || forced_q));
  assert_ignore_while_loading_R5: assert property (@(posedge clk) disable iff (!hw_rst_n)
    (host_wr_en && !load_done && !rd_dat_valid) |=> ($stable(cfg_q) && $stable(ctrl_lo_q)));
  assert_global_clears_R8: assert property (@(posedge clk) disable iff (!hw_rst_n)
    glob_req |=> (ctrl_reg[31] && cfg_q == '0 && sta_q == '0 && !load_done));
  assert_forced_no_frame_R9: assert property (@(posedge clk) disable iff (!hw_rst_n)
    forced_q |-> !ee_cs);
  assert_global_masks_unit_R11: assert property (@(posedge clk) disable iff (!hw_rst_n)
    (glob_req && unit_busy == '0) |=> (unit_busy == '0));
endmodule

// File: tb/tb_cfg_boot_ctrl.sv
module tb_cfg_boot_ctrl;
  localparam int CLK_PER = 10;

  logic        clk = 1'b0;
  logic        hw_rst_n = 1'b0;
  logic        strap_forced = 1'b0;
  logic        host_wr_en = 1'b0;
  logic        host_wr_sel = 1'b0;
  logic [31:0] host_wr_data = '0;
  logic        ee_cs, ee_sk, ee_di;
  logic        ee_do = 1'b0;
  logic [15:0] cfg_parm, subsys_vid, subsys_id, io_base;
  logic [31:0] ctrl_reg;
  logic [47:0] station_addr;
  logic        io_cyc_en, mem_cyc_en, bus_mst_en, rom_cyc_en, load_done;
  logic [3:0]  unit_rst;

  always #(CLK_PER/2) clk = ~clk;

  cfg_boot_ctrl dut (
    .clk(clk), .hw_rst_n(hw_rst_n), .strap_forced(strap_forced),
    .host_wr_en(host_wr_en), .host_wr_sel(host_wr_sel), .host_wr_data(host_wr_data),
    .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do),
    .cfg_parm(cfg_parm), .ctrl_reg(ctrl_reg), .subsys_vid(subsys_vid),
    .subsys_id(subsys_id), .station_addr(station_addr), .io_base(io_base),
    .io_cyc_en(io_cyc_en), .mem_cyc_en(mem_cyc_en), .bus_mst_en(bus_mst_en),
    .rom_cyc_en(rom_cyc_en), .unit_rst(unit_rst), .load_done(load_done)
  );

  // EEPROM images: word k sits at bits [16k+15:16k]
  localparam logic [111:0] IMG_TAB [0:2] = '{
    {16'h6655, 16'h4433, 16'h2211, 16'hC0DE, 16'h10EC, 16'h8001, 16'h1357},
    {16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF},
    {16'hAAAA, 16'h7FFF, 16'hFFFE, 16'h8000, 16'h0001, 16'hFFFF, 16'h0000}
  };

  int total = 0;
  int bad = 0;

  // serial EEPROM model
  logic [15:0] ee_mem [0:63];
  int          rcnt = 0;
  logic [8:0]  cmd_sh = '0;
  int          n_frames = 0;
  int          hdr_bad = 0;
  int          addr_log [0:15];
  time         t_rise = 0;
  time         sk_per = 0;
  time         sk_hi = 0;

  always @(posedge ee_cs) begin
    rcnt   = 0;
    cmd_sh = '0;
  end

  always @(posedge ee_sk) begin
    if (ee_cs) begin
      if (rcnt > 0) sk_per = $time - t_rise;
      t_rise = $time;
      if (rcnt < 9) cmd_sh = {cmd_sh[7:0], ee_di};
      rcnt++;
      if (rcnt == 9) begin
        if (cmd_sh[8:6] != 3'b110) hdr_bad++;
        if (n_frames < 16) addr_log[n_frames] = int'(cmd_sh[5:0]);
        n_frames++;
      end
    end
  end

  always @(negedge ee_sk) begin
    if (ee_cs) begin
      sk_hi = $time - t_rise;
      if (rcnt >= 9 && rcnt < 25) ee_do <= ee_mem[cmd_sh[5:0]][24-rcnt];
      else                        ee_do <= 1'b0;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic load_image(input int r);
    for (int k = 0; k < 64; k++)
      ee_mem[k] = (k < 7) ? IMG_TAB[r][16*k +: 16] : 16'hDEAD;
  endtask

  task automatic do_reset();
    @(negedge clk);
    hw_rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 cfg cleared in reset", 64'(cfg_parm), 64'h0);
    chk("R10 station cleared in reset", 64'(station_addr), 64'h0);
    n_frames = 0;
    hdr_bad  = 0;
    hw_rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wait_done();
    for (int k = 0; k < 5000; k++) begin
      if (load_done) break;
      @(negedge clk);
    end
  endtask

  task automatic host_write(input logic sel, input logic [31:0] data);
    @(negedge clk);
    host_wr_en   = 1'b1;
    host_wr_sel  = sel;
    host_wr_data = data;
    @(negedge clk);
    host_wr_en   = 1'b0;
  endtask

  task automatic chk_image(input string tag, input int r);
    chk({tag, " R1 cfg_parm"}, 64'(cfg_parm), 64'(IMG_TAB[r][15:0]));
    chk({tag, " R1 ctrl low"}, 64'(ctrl_reg[15:0]), 64'(IMG_TAB[r][31:16]));
    chk({tag, " R1 vid"}, 64'(subsys_vid), 64'(IMG_TAB[r][47:32]));
    chk({tag, " R1 ssid"}, 64'(subsys_id), 64'(IMG_TAB[r][63:48]));
    chk({tag, " R1 station"}, 64'(station_addr), 64'(IMG_TAB[r][111:64]));
    chk({tag, " R2 ctrl upper"}, 64'(ctrl_reg[31:16]), 64'h0);
  endtask

  initial begin
    #(CLK_PER * 150000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int c0, c1, c2, c31;
    // table walk
    for (int r = 0; r < 3; r++) begin
      load_image(r);
      do_reset();
      chk("R4 load_done low at start", 64'(load_done), 64'h0);
      wait_done();
      chk("R4 load_done high", 64'(load_done), 64'h1);
      chk_image("table", r);
      chk("R3 frame count", 64'(n_frames), 64'd7);
      chk("R3 header", 64'(hdr_bad), 64'd0);
      for (int k = 0; k < 7; k++) chk("R3 address order", 64'(addr_log[k]), 64'(k));
      chk("R9 io_base off", 64'(io_base), 64'h0);
      chk("R9 enables off", 64'({io_cyc_en, mem_cyc_en, bus_mst_en, rom_cyc_en}), 64'h0);
    end
    chk("R3 sk period", 64'(sk_per / CLK_PER), 64'd8);
    chk("R3 sk high time", 64'(sk_hi / CLK_PER), 64'd4);

    // R5: writes during preload, incl. the cycle the last word is stored
    load_image(0);
    do_reset();
    repeat (20) @(negedge clk);
    host_write(1'b1, 32'h0000_BEEF);
    host_write(1'b0, 32'h8001_4321);
    repeat (7) @(negedge ee_cs);
    host_wr_en   = 1'b1;
    host_wr_sel  = 1'b1;
    host_wr_data = 32'h0000_F00D;
    @(posedge clk);
    @(negedge clk);
    host_wr_en = 1'b0;
    chk("R4 done after last word", 64'(load_done), 64'h1);
    chk("R5 late write ignored", 64'(cfg_parm), 64'h1357);
    chk("R5 ctrl untouched", 64'(ctrl_reg), 64'h0000_8001);
    chk("R5 no unit reset", 64'(unit_rst), 64'h0);

    // R6: host writes after preload
    host_write(1'b1, 32'h0000_BEEF);
    chk("R6 cfg write", 64'(cfg_parm), 64'hBEEF);
    host_write(1'b0, 32'h7FF0_1234);
    chk("R6 ctrl write", 64'(ctrl_reg), 64'h7FF0_1234);

    // R7: unit resets 0 and 2
    host_write(1'b0, 32'h0005_5678);
    chk("R7 ctrl shows active units", 64'(ctrl_reg), 64'h0005_5678);
    c0 = 0; c1 = 0; c2 = 0;
    for (int k = 0; k < 40; k++) begin
      if (unit_rst[0]) c0++;
      if (unit_rst[1]) c1++;
      if (unit_rst[2]) c2++;
      @(negedge clk);
    end
    chk("R7 unit0 pulse length", 64'(c0), 64'd16);
    chk("R7 unit2 pulse length", 64'(c2), 64'd16);
    chk("R7 unit1 untouched", 64'(c1), 64'd0);
    chk("R7 ctrl after pulses", 64'(ctrl_reg), 64'h0000_5678);

    // R8 + R11: global reset together with unit 2 request
    load_image(2);
    host_write(1'b0, 32'h8004_0000);
    chk("R8 cfg cleared", 64'(cfg_parm), 64'h0);
    chk("R8 station cleared", 64'(station_addr), 64'h0);
    chk("R8 load_done low", 64'(load_done), 64'h0);
    c0 = 0; c2 = 0; c31 = 0;
    for (int k = 0; k < 40; k++) begin
      if (unit_rst[0]) c0++;
      if (unit_rst[2]) c2++;
      if (ctrl_reg[31]) c31++;
      @(negedge clk);
    end
    chk("R8 global bit length", 64'(c31), 64'd4);
    chk("R8 all units held", 64'(c0), 64'd4);
    chk("R11 unit2 only global length", 64'(c2), 64'd4);
    wait_done();
    chk_image("R8 reload", 2);

    // R10: hardware reset discards a host value
    host_write(1'b1, 32'h0000_ABCD);
    chk("R10 pre-reset value", 64'(cfg_parm), 64'hABCD);
    load_image(0);
    do_reset();
    wait_done();
    chk("R10 reload cfg", 64'(cfg_parm), 64'h1357);

    // R9: forced strap
    strap_forced = 1'b1;
    do_reset();
    chk("R9 done at once", 64'(load_done), 64'h1);
    repeat (300) @(negedge clk);
    chk("R9 no frames", 64'(n_frames), 64'd0);
    chk("R9 io_base", 64'(io_base), 64'h0200);
    chk("R9 enables", 64'({io_cyc_en, mem_cyc_en, bus_mst_en, rom_cyc_en}), 64'b1010);
    chk("R9 config zero", 64'({cfg_parm, station_addr}), 64'h0);
    strap_forced = 1'b0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule